// File: doc/BRIEF.md
# Three-Stage Character Buffer Chain

The block is a cascade of three character-wide holding registers, each paired with a busy flag. A busy flag is set when its register holds a character and clear when the register is empty. Characters enter the first register from a source, which is either a memory read port with cursor search on transmit or a serial receiver on receive. They are passed forward one register per strobe and leave the third register toward a sink, which is a serial transmitter on transmit or a memory write port on receive. A register passes its character forward when the next register is empty, or when the next register is handing its own character on during the same cycle. As a result, all three registers can shift together.

The events that fill and empty the flags depend on the mode:

- **Transmit:** a character is accepted when the cursor is found, and a cursor-advance pulse holds the first flag low.
- **Receive:** the start-of-text character and the address character that follows it are swallowed, and only the body is buffered.
- **Polling conversational:** a header-entry pulse jams an end-of-text (ETX) code into the first register and holds it there until memory reports that an ETX was found.

When the sink takes an ETX from the third register, the message is over and all three flags clear together.

Top module: `bbchain_top`

## Requirements
- R1: A synchronous active-high reset empties all three registers. After reset, `busy_o` reads 3'b000 and `snk_data_o` reads 0.
- R2: A character moves from register 1 to 2 when register 1 is full and register 2 is empty or being emptied in the same cycle. The 2-to-3 move follows the same rule against register 3. Both moves can happen in one cycle. The bit order is `busy_o[0]` for register 1 through `busy_o[2]` for register 3.
- R3: Every accepted body character reaches `snk_data_o` exactly once and in arrival order, under any pattern of source and sink stalls.
- R4: When the sink takes a character equal to ETX (8'h03) from register 3, all three flags clear on the next edge. Characters still held in registers 1 and 2 are dropped.
- R5: In receive mode the first accepted character equal to STX (8'h02) and the one character after it are consumed but not buffered, and any character before that STX is dropped too. Buffering starts with the next character and stops again after end of message or when receive mode is left.
- R6: In transmit mode, while `cursor_step_i` is high, `src_ready_o` is low and register 1 accepts nothing.
- R7: In polling conversational transmit mode, a header-entry pulse on an empty register 1 loads ETX and sets `busy_o[0]`. While that marker is held, `src_ready_o` is low and the marker does not move on to register 2.
- R8: An ETX-found pulse clears the held marker without forwarding it. The next accepted character takes its place and is the first to reach the sink.
- R9: A sink take while register 3 is empty has no effect on `busy_o`.
- R10: After a sink take, register 3 reads empty unless register 2 refills it in the same cycle, in which case it stays full with the new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_mode_i | input | 1 | 1 = receive, 0 = transmit |
| poll_mode_i | input | 1 | Polling conversational variant of transmit |
| src_valid_i | input | 1 | Source offers a character (cursor hit or parity-bit time) |
| src_data_i | input | 8 | Offered character |
| src_ready_o | output | 1 | Offered character is consumed at this edge |
| cursor_step_i | input | 1 | Cursor advance pulse (transmit) |
| hdr_enter_i | input | 1 | Header-entry pulse (polling) |
| etx_found_i | input | 1 | Memory located an ETX (polling) |
| snk_take_i | input | 1 | Sink consumes register 3 (parity-bit time or write to memory) |
| snk_data_o | output | 8 | Content of register 3 |
| busy_o | output | 3 | Busy flags, bit 0 = register 1 |

## Verification
The bench fills all three registers and then takes a single character. A design that did not allow both moves in one cycle would leave a bubble, so register 1 would stay full or register 3 would empty. It then places an ETX in register 3 with two characters behind it; a design that cleared only register 3 would later deliver those stale characters. It also checks that a polling marker neither leaks to the sink nor blocks the first real character once released. In receive mode it sends a stray byte, then STX, then an address, and checks that a design that counted the wrong framing characters buffers too many or too few. Randomly stalled messages in all three modes run against a scoreboard that catches any loss, duplication or reordering.

// File: rtl/bbchain_pkg.sv
package bbchain_pkg;

    localparam int CHAR_W = 8;
    localparam int NSTAGE = 3;

    typedef logic [CHAR_W-1:0] char_t;

    localparam char_t CH_ETX = 8'h03;
    localparam char_t CH_STX = 8'h02;

    typedef enum logic [1:0] {
        FR_WAIT_STX  = 2'd0,
        FR_WAIT_ADDR = 2'd1,
        FR_BODY      = 2'd2
    } frame_st_e;

    typedef struct packed {
        logic mv12;
        logic mv23;
        logic take3;
        logic eom;
    } strobe_t;

    function automatic logic char_match(char_t a, char_t b);
        return a == b;
    endfunction

endpackage

// File: rtl/bbchain_frame.sv
module bbchain_frame
    import bbchain_pkg::*;
#(
    parameter char_t STX_CODE = CH_STX
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_mode_i,
    input  logic  consume_i,
    input  char_t src_data_i,
    input  logic  eom_i,
    output logic  pass_o,
    output logic  discard_o
);

    frame_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!rx_mode_i || eom_i) begin
            st_d = FR_WAIT_STX;
        end else if (consume_i) begin
            case (st_q)
                FR_WAIT_STX:  if (char_match(src_data_i, STX_CODE)) st_d = FR_WAIT_ADDR;
                FR_WAIT_ADDR: st_d = FR_BODY;
                FR_BODY:      st_d = FR_BODY;
                default:      st_d = FR_WAIT_STX;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= FR_WAIT_STX;
        else     st_q <= st_d;
    end

    assign pass_o    = !rx_mode_i || (st_q == FR_BODY);
    assign discard_o = rx_mode_i && (st_q != FR_BODY);

endmodule

// File: rtl/bbchain_ctrl.sv
module bbchain_ctrl
    import bbchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_mode_i,
    input  logic              poll_mode_i,
    input  logic              hdr_enter_i,
    input  logic              etx_found_i,
    input  logic              cursor_step_i,
    input  logic              src_valid_i,
    input  logic              pass_i,
    input  logic              discard_i,
    input  logic              snk_take_i,
    input  logic              tail_is_etx_i,
    output logic              src_ready_o,
    output logic              ld_head_o,
    output logic              jam_o,
    output logic              marker_o,
    output strobe_t           stb_o,
    output logic [NSTAGE-1:0] busy_o
);

    logic [NSTAGE-1:0] busy_q;
    logic              marker_q;
    logic              jam_req, room1, can_load, cursor_block;
    strobe_t           stb;

    always_comb begin
        stb.take3 = busy_q[2] && snk_take_i;
        stb.eom   = stb.take3 && tail_is_etx_i;
        stb.mv23  = busy_q[1] && (!busy_q[2] || stb.take3) && !stb.eom;
        stb.mv12  = busy_q[0] && !marker_q && (!busy_q[1] || stb.mv23) && !stb.eom;
    end

    assign jam_req      = poll_mode_i && !rx_mode_i && hdr_enter_i;
    assign jam_o        = jam_req && !busy_q[0] && !stb.eom;
    assign room1        = !busy_q[0] || stb.mv12;
    assign cursor_block = !rx_mode_i && cursor_step_i;
    assign can_load     = room1 && !marker_q && !jam_req && !cursor_block;
    assign src_ready_o  = !stb.eom && (discard_i || can_load);
    assign ld_head_o    = src_valid_i && src_ready_o && pass_i;

    always_ff @(posedge clk) begin
        if (rst || stb.eom) begin
            busy_q   <= '0;
            marker_q <= 1'b0;
        end else begin
            if (jam_o || ld_head_o)             busy_q[0] <= 1'b1;
            else if (stb.mv12)                  busy_q[0] <= 1'b0;
            else if (marker_q && etx_found_i)   busy_q[0] <= 1'b0;

            if (stb.mv12)      busy_q[1] <= 1'b1;
            else if (stb.mv23) busy_q[1] <= 1'b0;

            if (stb.mv23)       busy_q[2] <= 1'b1;
            else if (stb.take3) busy_q[2] <= 1'b0;

            if (jam_o)                        marker_q <= 1'b1;
            else if (marker_q && etx_found_i) marker_q <= 1'b0;
        end
    end

    assign busy_o   = busy_q;
    assign marker_o = marker_q;
    assign stb_o    = stb;

endmodule

// File: rtl/bbchain_datapath.sv
module bbchain_datapath
    import bbchain_pkg::*;
#(
    parameter char_t ETX_CODE = CH_ETX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              jam_i,
    input  logic              ld_head_i,
    input  char_t             src_data_i,
    input  logic [NSTAGE-1:0] shift_i,
    output char_t             mid_o,
    output char_t             tail_o
);

    char_t d_q [NSTAGE];

    always_ff @(posedge clk) begin
        if (rst)            d_q[0] <= '0;
        else if (jam_i)     d_q[0] <= ETX_CODE;
        else if (ld_head_i) d_q[0] <= src_data_i;
    end

    for (genvar i = 1; i < NSTAGE; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)             d_q[i] <= '0;
            else if (shift_i[i]) d_q[i] <= d_q[i-1];
        end
    end

    assign mid_o  = d_q[NSTAGE-2];
    assign tail_o = d_q[NSTAGE-1];

endmodule

// File: rtl/bbchain_top.sv
module bbchain_top
    import bbchain_pkg::*;
#(
    parameter char_t ETX_CODE = CH_ETX,
    parameter char_t STX_CODE = CH_STX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_mode_i,
    input  logic              poll_mode_i,
    input  logic              src_valid_i,
    input  logic [CHAR_W-1:0] src_data_i,
    output logic              src_ready_o,
    input  logic              cursor_step_i,
    input  logic              hdr_enter_i,
    input  logic              etx_found_i,
    input  logic              snk_take_i,
    output logic [CHAR_W-1:0] snk_data_o,
    output logic [NSTAGE-1:0] busy_o
);

    logic    pass, discard, ld_head, jam, marker;
    logic    mv12, mv23, eom;
    strobe_t stb;
    char_t   mid_data, tail_data;

    bbchain_frame #(.STX_CODE(STX_CODE)) frame_i (
        .clk        (clk),
        .rst        (rst),
        .rx_mode_i  (rx_mode_i),
        .consume_i  (src_valid_i && src_ready_o),
        .src_data_i (src_data_i),
        .eom_i      (eom),
        .pass_o     (pass),
        .discard_o  (discard)
    );

    bbchain_ctrl ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .rx_mode_i     (rx_mode_i),
        .poll_mode_i   (poll_mode_i),
        .hdr_enter_i   (hdr_enter_i),
        .etx_found_i   (etx_found_i),
        .cursor_step_i (cursor_step_i),
        .src_valid_i   (src_valid_i),
        .pass_i        (pass),
        .discard_i     (discard),
        .snk_take_i    (snk_take_i),
        .tail_is_etx_i (char_match(tail_data, ETX_CODE)),
        .src_ready_o   (src_ready_o),
        .ld_head_o     (ld_head),
        .jam_o         (jam),
        .marker_o      (marker),
        .stb_o         (stb),
        .busy_o        (busy_o)
    );

    assign mv12 = stb.mv12;
    assign mv23 = stb.mv23;
    assign eom  = stb.eom;

    bbchain_datapath #(.ETX_CODE(ETX_CODE)) dp_i (
        .clk        (clk),
        .rst        (rst),
        .jam_i      (jam),
        .ld_head_i  (ld_head),
        .src_data_i (src_data_i),
        .shift_i    ({mv23, mv12, 1'b0}),
        .mid_o      (mid_data),
        .tail_o     (tail_data)
    );

    assign snk_data_o = tail_data;

endmodule

// File: rtl/bbchain_chk.sv
module bbchain_chk
    import bbchain_pkg::*;
#(
    parameter char_t ETX_CODE = CH_ETX
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_mode_i,
    input logic              poll_mode_i,
    input logic              hdr_enter_i,
    input logic              etx_found_i,
    input logic              cursor_step_i,
    input logic              snk_take_i,
    input logic              src_ready_o,
    input char_t             snk_data_o,
    input logic [NSTAGE-1:0] busy_o,
    input logic              mv12,
    input logic              mv23,
    input logic              eom,
    input logic              marker,
    input char_t             mid_data
);

    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (busy_o == '0)); // R1

    AST_MV12_FILLS: assert property (@(posedge clk) disable iff (rst)
        mv12 |=> busy_o[1]); // R2

    AST_MV23_CARRIES: assert property (@(posedge clk) disable iff (rst)
        mv23 |=> (busy_o[2] && snk_data_o == $past(mid_data))); // R2

    AST_EOM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (busy_o[2] && snk_take_i && snk_data_o == ETX_CODE) |=> (busy_o == '0)); // R4

    AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rx_mode_i && cursor_step_i && !busy_o[0] && !(poll_mode_i && hdr_enter_i))
        |=> !busy_o[0]); // R6

    AST_MARKER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        marker |-> (!src_ready_o && !mv12)); // R7

    AST_FOUND_FREES: assert property (@(posedge clk) disable iff (rst)
        (marker && etx_found_i && !eom) |=> !busy_o[0]); // R8

    AST_IDLE_TAKE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o[2] && !mv23) |=> !busy_o[2]); // R9

    AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (busy_o[2] && snk_take_i && !mv23) |=> !busy_o[2]); // R10

endmodule

bind bbchain_top bbchain_chk #(.ETX_CODE(ETX_CODE)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .rx_mode_i     (rx_mode_i),
    .poll_mode_i   (poll_mode_i),
    .hdr_enter_i   (hdr_enter_i),
    .etx_found_i   (etx_found_i),
    .cursor_step_i (cursor_step_i),
    .snk_take_i    (snk_take_i),
    .src_ready_o   (src_ready_o),
    .snk_data_o    (snk_data_o),
    .busy_o        (busy_o),
    .mv12          (mv12),
    .mv23          (mv23),
    .eom           (eom),
    .marker        (marker),
    .mid_data      (mid_data)
);

// File: tb/bbchain_top_tb_top.sv
module bbchain_top_tb_top;
    import bbchain_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_mode_i = 1'b0, poll_mode_i = 1'b0;
    logic        src_valid_i = 1'b0;
    logic [7:0]  src_data_i = '0;
    logic        src_ready_o;
    logic        cursor_step_i = 1'b0, hdr_enter_i = 1'b0, etx_found_i = 1'b0;
    logic        snk_take_i = 1'b0;
    logic [7:0]  snk_data_o;
    logic [2:0]  busy_o;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    bit    mon_en = 0;
    bit    cur_rand = 0;
    logic [7:0] q[$];

    always #5 clk = ~clk;

    bbchain_top dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            snk_take_i = ($urandom % 3) != 0;
            if (snk_take_i && busy_o[2]) begin
                if (q.size() == 0) chk(0, "R3", "unexpected output", snk_data_o, 0);
                else begin
                    logic [7:0] e;
                    e = q.pop_front();
                    chk(snk_data_o == e, "R3", "order", snk_data_o, e);
                end
            end
        end
    end

    // called right after a negedge; returns at the negedge after acceptance
    task automatic put(input logic [7:0] c, input bit push);
        bit got;
        got = 0;
        src_valid_i = 1'b1;
        src_data_i  = c;
        while (!got) begin
            cursor_step_i = cur_rand && !rx_mode_i && (($urandom % 4) == 0);
            #1;
            if (src_ready_o) got = 1;
            else @(negedge clk);
        end
        if (push) q.push_back(c);
        @(negedge clk);
        src_valid_i   = 1'b0;
        cursor_step_i = 1'b0;
    endtask

    task automatic take_one();
        snk_take_i = 1'b1;
        @(negedge clk);
        snk_take_i = 1'b0;
    endtask

    task automatic rand_msg(input int mode);
        int n;
        rx_mode_i   = (mode == 1);
        poll_mode_i = (mode == 2);
        cur_rand    = (mode != 1);
        @(negedge clk);
        if (mode == 2) begin
            hdr_enter_i = 1'b1;
            @(negedge clk);
            hdr_enter_i = 1'b0;
            repeat ($urandom % 4) @(negedge clk);
            etx_found_i = 1'b1;
            @(negedge clk);
            etx_found_i = 1'b0;
        end
        if (mode == 1) begin
            put(CH_STX, 0);
            put(8'($urandom), 0);
        end
        n = 1 + ($urandom % 12);
        for (int i = 0; i < n; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            if (c == CH_ETX) c = 8'h41;
            repeat ($urandom % 3) @(negedge clk);
            put(c, 1);
        end
        put(CH_ETX, 1);
        for (int k = 0; k < 300 && (q.size() != 0 || busy_o != 3'b000); k++) @(negedge clk);
        chk(q.size() == 0, "R3", "all delivered", q.size(), 0);
        chk(busy_o == 3'b000, "R4", "empty after message end", busy_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(busy_o == 3'b000, "R1", "flags after reset", busy_o, 0);
        chk(snk_data_o == 8'h00, "R1", "tail after reset", snk_data_o, 0);
        chk(src_ready_o == 1'b1, "R1", "ready after reset", src_ready_o, 1);
        @(negedge clk);

        // R2 fill then simultaneous shift
        put(8'hA1, 0); put(8'hB2, 0); put(8'hC3, 0);
        repeat (2) @(negedge clk);
        chk(busy_o == 3'b111, "R2", "chain full", busy_o, 3'b111);
        chk(snk_data_o == 8'hA1, "R2", "first at tail", snk_data_o, 8'hA1);
        take_one();
        chk(busy_o == 3'b110, "R2", "double shift flags", busy_o, 3'b110);
        chk(snk_data_o == 8'hB2, "R2", "double shift data", snk_data_o, 8'hB2);
        take_one();
        chk(busy_o == 3'b100, "R10", "refilled tail stays full", busy_o, 3'b100);
        chk(snk_data_o == 8'hC3, "R10", "refill data", snk_data_o, 8'hC3);
        take_one();
        chk(busy_o == 3'b000, "R10", "tail drained", busy_o, 0);
        take_one();
        chk(busy_o == 3'b000, "R9", "take on empty", busy_o, 0);

        // R4 end of message drops followers
        put(CH_ETX, 0); put(8'h55, 0); put(8'h66, 0);
        repeat (2) @(negedge clk);
        chk(busy_o == 3'b111, "R4", "etx with followers", busy_o, 3'b111);
        take_one();
        chk(busy_o == 3'b000, "R4", "all flags cleared", busy_o, 0);
        put(8'h77, 0);
        repeat (2) @(negedge clk);
        chk(snk_data_o == 8'h77, "R4", "no stale followers", snk_data_o, 8'h77);
        take_one();

        // R6 cursor step
        cursor_step_i = 1'b1;
        src_valid_i   = 1'b1;
        src_data_i    = 8'h33;
        #1;
        chk(src_ready_o == 1'b0, "R6", "ready during cursor step", src_ready_o, 0);
        @(negedge clk);
        chk(busy_o == 3'b000, "R6", "nothing loaded", busy_o, 0);
        cursor_step_i = 1'b0;
        src_valid_i   = 1'b0;

        // R7 / R8 polling marker
        poll_mode_i = 1'b1;
        hdr_enter_i = 1'b1;
        @(negedge clk);
        hdr_enter_i = 1'b0;
        #1;
        chk(busy_o == 3'b001, "R7", "marker loaded", busy_o, 3'b001);
        chk(src_ready_o == 1'b0, "R7", "ready while held", src_ready_o, 0);
        repeat (3) @(negedge clk);
        chk(busy_o == 3'b001, "R7", "marker stays put", busy_o, 3'b001);
        etx_found_i = 1'b1;
        @(negedge clk);
        etx_found_i = 1'b0;
        #1;
        chk(busy_o == 3'b000, "R8", "marker released", busy_o, 0);
        chk(src_ready_o == 1'b1, "R8", "ready after release", src_ready_o, 1);
        @(negedge clk);
        put(8'h41, 0);
        repeat (2) @(negedge clk);
        chk(snk_data_o == 8'h41 && busy_o == 3'b100, "R8", "first char at tail",
            snk_data_o, 8'h41);
        take_one();
        poll_mode_i = 1'b0;

        // R5 receive framing
        rx_mode_i = 1'b1;
        @(negedge clk);
        put(8'h55, 0); put(CH_STX, 0); put(8'h10, 0);
        repeat (3) @(negedge clk);
        chk(busy_o == 3'b000, "R5", "framing chars swallowed", busy_o, 0);
        put(8'h20, 0);
        repeat (2) @(negedge clk);
        chk(busy_o == 3'b100 && snk_data_o == 8'h20, "R5", "body buffered",
            snk_data_o, 8'h20);
        take_one();
        rx_mode_i = 1'b0;
        @(negedge clk);

        // R3 random scoreboard run
        mon_en = 1;
        for (int m = 0; m < 30; m++) rand_msg(m % 3);
        mon_en     = 0;
        snk_take_i = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule